// File: doc/BRIEF.md
# Block address translation array

This block translates a 32-bit effective address through a small set of large, software-loaded address blocks. Two banks of entries are held, one consulted only for instruction fetches and one consulted only for loads and stores. Each entry is a pair of 32-bit words. The upper word holds the block's effective base, a block-length field and two validity bits, one per privilege level. The lower word holds the block's physical base and a two-bit protection code.

A lookup is purely combinational. The effective address, the access kind and the privilege level go in. In the same cycle the block returns the physical address, the read/write/execute permissions of the deciding entry, that entry's index and a status code. The status code says miss, hit with access granted, or hit with access denied. Entries are loaded one word at a time through a single synchronous write port. A missed lookup is left to whatever walks the page tables.

Top module: `blk_xlate_array`

## Requirements
- R1: After reset every word of both banks is zero, so every lookup reports a miss.
- R2: An entry's region matches when lookup address bits 31:28 equal upper-word bits 31:28. Address bits 27:17 must also equal upper-word bits 27:17 once the bits set in the length mask are cleared from the address. The length mask is upper-word bits 12:2, applied to address bits 27:17 bit for bit.
- R3: For a supervisor lookup (`lk_user`=0) an entry is valid when upper-word bit 1 is set. For a user lookup (`lk_user`=1) it is valid when upper-word bit 0 is set. A region match on an entry that is not valid for the current level is skipped as if it had not matched.
- R4: `lk_perm` is {read, write, execute}, taken from lower-word bits 1:0. Code 0 gives 3'b000, code 2 gives 3'b111, and codes 1 and 3 give 3'b101.
- R5: On a hit, `lk_pa` is built in three parts. Bits 31:28 come from lower-word bits 31:28. Bits 27:17 are the address bits under the length mask ORed with lower-word bits 27:17. Bits 16:0 are copied from the address.
- R6: Entries are examined from index 0 upward, and the lowest-indexed matching valid entry decides the result, even if it denies the access. `lk_entry` gives its index.
- R7: `lk_kind` 2'b00 is a load, 2'b01 a store, and 2'b10 or 2'b11 a fetch. Fetches consult only the instruction bank, and loads and stores only the data bank.
- R8: `lk_status` is 2'd0 for a miss, 2'd1 when the deciding entry grants the access and 2'd2 when it denies it. A load needs read, a store needs write and a fetch needs execute permission.
- R9: On a miss `lk_pa`, `lk_perm` and `lk_entry` are all zero.
- R10: A write with `wr_en`=1 at a rising edge stores `wr_data` into the word chosen by `wr_instr` (1 selects the instruction bank), `wr_idx` and `wr_lower` (1 selects the lower word). Lookups see the new value from just after that edge and not before, and no other word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one entry word |
| wr_instr | input | 1 | Bank select for the write: 1 instruction, 0 data |
| wr_idx | input | IDX_W (2) | Entry index for the write |
| wr_lower | input | 1 | Word select for the write: 1 lower, 0 upper |
| wr_data | input | 32 | Word to store |
| lk_ea | input | 32 | Effective address to translate |
| lk_kind | input | 2 | Access kind: load, store or fetch |
| lk_user | input | 1 | Privilege level: 1 user, 0 supervisor |
| lk_pa | output | 32 | Translated physical address |
| lk_perm | output | 3 | Permissions {read, write, execute} of the deciding entry |
| lk_status | output | 2 | Miss, granted or denied |
| lk_entry | output | IDX_W (2) | Index of the deciding entry |

## Verification
A corrupted entry word shows up combinationally, in the very cycle a lookup falls in that entry's region. It appears as a wrong physical address, a wrong permission triple or a hit where a miss was due. A broken priority chain is seen when overlapping entries are probed: a later entry's address or index appears where the earlier entry should have decided. A bank-select fault shows as fetches returning data-bank translations, or as a write on one bank changing lookups on the other from the next cycle.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

  localparam int WORD_W = 32;
  localparam int SEG_HI = 31;
  localparam int SEG_LO = 28;
  localparam int BLK_HI = 27;
  localparam int BLK_LO = 17;
  localparam int LEN_HI = 12;
  localparam int LEN_LO = 2;
  localparam int BLK_W  = BLK_HI - BLK_LO + 1;
  localparam int OFF_W  = BLK_LO;

  typedef enum logic [1:0] {
    XS_MISS  = 2'd0,
    XS_GRANT = 2'd1,
    XS_DENY  = 2'd2
  } xstat_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

  // Length mask over address bits 27:17
  function automatic logic [BLK_W-1:0] len_mask(input logic [WORD_W-1:0] up);
    return up[LEN_HI:LEN_LO];
  endfunction

  function automatic logic region_hit(input logic [WORD_W-1:0] up,
                                      input logic [WORD_W-1:0] ea);
    logic seg_eq;
    logic blk_eq;
    seg_eq = (ea[SEG_HI:SEG_LO] == up[SEG_HI:SEG_LO]);
    blk_eq = ((ea[BLK_HI:BLK_LO] & ~len_mask(up)) == up[BLK_HI:BLK_LO]);
    return seg_eq && blk_eq;
  endfunction

  function automatic logic level_ok(input logic [WORD_W-1:0] up, input logic user);
    return user ? up[0] : up[1];
  endfunction

  function automatic perm_t decode_prot(input logic [WORD_W-1:0] lo);
    perm_t p;
    case (lo[1:0])
      2'd0:    p = '{rd: 1'b0, wr: 1'b0, ex: 1'b0};
      2'd2:    p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
      default: p = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
    endcase
    return p;
  endfunction

  function automatic logic [WORD_W-1:0] phys_addr(input logic [WORD_W-1:0] up,
                                                  input logic [WORD_W-1:0] lo,
                                                  input logic [WORD_W-1:0] ea);
    logic [BLK_W-1:0] mid;
    mid = (ea[BLK_HI:BLK_LO] & len_mask(up)) | lo[BLK_HI:BLK_LO];
    return {lo[SEG_HI:SEG_LO], mid, ea[OFF_W-1:0]};
  endfunction

  // Permission bit the access kind needs
  function automatic perm_t needed(input logic [1:0] kind);
    perm_t p;
    p = '0;
    if (kind[1])      p.ex = 1'b1;
    else if (kind[0]) p.wr = 1'b1;
    else              p.rd = 1'b1;
    return p;
  endfunction

  function automatic logic allowed(input perm_t p, input logic [1:0] kind);
    return |(p & needed(kind));
  endfunction

endpackage

// File: rtl/blkx_bank.sv
module blkx_bank #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2,
  parameter int WORD_W  = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic                           wr_lower,
  input  logic [WORD_W-1:0]              wr_data,
  output logic [ENTRIES-1:0][WORD_W-1:0] upper_q,
  output logic [ENTRIES-1:0][WORD_W-1:0] lower_q
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel_e;
    assign sel_e = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        upper_q[e] <= '0;
        lower_q[e] <= '0;
      end else if (sel_e) begin
        if (wr_lower) lower_q[e] <= wr_data;
        else          upper_q[e] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/blkx_probe.sv
module blkx_probe
  import blkx_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic [ENTRIES-1:0][WORD_W-1:0] upper,
  input  logic [ENTRIES-1:0][WORD_W-1:0] lower,
  input  logic [WORD_W-1:0]              ea,
  input  logic                           user,
  output logic [ENTRIES-1:0]             hit_vec,
  output logic [ENTRIES-1:0][WORD_W-1:0] pa_arr,
  output perm_t [ENTRIES-1:0]            perm_arr
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic region_e;
    logic valid_e;
    assign region_e    = region_hit(upper[e], ea);
    assign valid_e     = level_ok(upper[e], user);
    assign hit_vec[e]  = region_e && valid_e;
    assign pa_arr[e]   = phys_addr(upper[e], lower[e], ea);
    assign perm_arr[e] = decode_prot(lower[e]);
  end

endmodule

// File: rtl/blkx_pick.sv
module blkx_pick
  import blkx_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic [ENTRIES-1:0]             hit_vec,
  input  logic [ENTRIES-1:0][WORD_W-1:0] pa_arr,
  input  perm_t [ENTRIES-1:0]            perm_arr,
  output logic [ENTRIES-1:0]             sel_vec,
  output logic                           any_hit,
  output logic [IDX_W-1:0]               sel_idx,
  output logic [WORD_W-1:0]              sel_pa,
  output perm_t                          sel_perm
);

  // Lowest index wins
  always_comb begin
    logic found;
    found   = 1'b0;
    sel_vec = '0;
    sel_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i] && !found) begin
        sel_vec[i] = 1'b1;
        sel_idx    = IDX_W'(i);
        found      = 1'b1;
      end
    end
  end

  assign any_hit = |hit_vec;

  // AND-OR mux: zero when nothing is selected
  always_comb begin
    sel_pa   = '0;
    sel_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      sel_pa   = sel_pa | (pa_arr[i] & {WORD_W{sel_vec[i]}});
      sel_perm = sel_perm | (perm_arr[i] & {3{sel_vec[i]}});
    end
  end

endmodule

// File: rtl/blk_xlate_array.sv
module blk_xlate_array
  import blkx_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_instr,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_lower,
  input  logic [31:0]       wr_data,
  input  logic [31:0]       lk_ea,
  input  logic [1:0]        lk_kind,
  input  logic              lk_user,
  output logic [31:0]       lk_pa,
  output logic [2:0]        lk_perm,
  output logic [1:0]        lk_status,
  output logic [IDX_W-1:0]  lk_entry
);

  localparam int N_SIDES = 2;

  logic [ENTRIES-1:0][WORD_W-1:0] bank_up [N_SIDES];
  logic [ENTRIES-1:0][WORD_W-1:0] bank_lo [N_SIDES];

  // Side 0 data, side 1 instruction
  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    logic side_wr;
    assign side_wr = wr_en && (wr_instr == s[0]);

    blkx_bank #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (side_wr),
      .wr_idx   (wr_idx),
      .wr_lower (wr_lower),
      .wr_data  (wr_data),
      .upper_q  (bank_up[s]),
      .lower_q  (bank_lo[s])
    );
  end

  logic                           is_fetch;
  logic [ENTRIES-1:0][WORD_W-1:0] cur_up;
  logic [ENTRIES-1:0][WORD_W-1:0] cur_lo;

  assign is_fetch = lk_kind[1];
  assign cur_up   = is_fetch ? bank_up[1] : bank_up[0];
  assign cur_lo   = is_fetch ? bank_lo[1] : bank_lo[0];

  logic [ENTRIES-1:0]             hit_vec;
  logic [ENTRIES-1:0]             sel_vec;
  logic [ENTRIES-1:0][WORD_W-1:0] pa_arr;
  perm_t [ENTRIES-1:0]            perm_arr;
  logic                           any_hit;
  logic [IDX_W-1:0]               sel_idx;
  logic [WORD_W-1:0]              sel_pa;
  perm_t                          sel_perm;
  logic                           grant_ok;
  xstat_e                         status;

  blkx_probe #(.ENTRIES(ENTRIES)) u_probe (
    .upper    (cur_up),
    .lower    (cur_lo),
    .ea       (lk_ea),
    .user     (lk_user),
    .hit_vec  (hit_vec),
    .pa_arr   (pa_arr),
    .perm_arr (perm_arr)
  );

  blkx_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .hit_vec  (hit_vec),
    .pa_arr   (pa_arr),
    .perm_arr (perm_arr),
    .sel_vec  (sel_vec),
    .any_hit  (any_hit),
    .sel_idx  (sel_idx),
    .sel_pa   (sel_pa),
    .sel_perm (sel_perm)
  );

  assign grant_ok = allowed(sel_perm, lk_kind);

  always_comb begin
    if (!any_hit)      status = XS_MISS;
    else if (grant_ok) status = XS_GRANT;
    else               status = XS_DENY;
  end

  assign lk_status = status;
  assign lk_pa     = sel_pa;
  assign lk_perm   = sel_perm;
  assign lk_entry  = sel_idx;

endmodule

// File: rtl/blkx_chk.sv
module blkx_chk
  import blkx_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [31:0]        lk_ea,
  input logic [1:0]         lk_kind,
  input logic               lk_user,
  input logic [31:0]        lk_pa,
  input logic [2:0]         lk_perm,
  input logic [1:0]         lk_status,
  input logic [IDX_W-1:0]   lk_entry,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] sel_vec
);

  logic need_met;
  assign need_met = |(lk_perm & needed(lk_kind));

  // R8
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_status != 2'd3);

  // R9
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_status == 2'd0) |-> (lk_pa == '0 && lk_perm == '0 && lk_entry == '0));

  // R8
  grant_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_status == 2'd1) |-> need_met);

  // R8
  deny_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_status == 2'd2) |-> !need_met);

  // R4
  perm_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_perm == 3'b000) || (lk_perm == 3'b101) || (lk_perm == 3'b111));

  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_status != 2'd0) |-> (lk_pa[16:0] == lk_ea[16:0]));

  // R6
  single_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec) && ((sel_vec & ~hit_vec) == '0));

  // R6
  hit_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) == (lk_status != 2'd0));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(lk_ea) && $stable(lk_kind) && $stable(lk_user))
      |-> ($stable(lk_status) && $stable(lk_pa) && $stable(lk_entry)));

endmodule

bind blk_xlate_array blkx_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .lk_ea     (lk_ea),
  .lk_kind   (lk_kind),
  .lk_user   (lk_user),
  .lk_pa     (lk_pa),
  .lk_perm   (lk_perm),
  .lk_status (lk_status),
  .lk_entry  (lk_entry),
  .hit_vec   (hit_vec),
  .sel_vec   (sel_vec)
);

// File: tb/sim_blk_xlate_array.sv
module sim_blk_xlate_array;

  localparam logic [1:0] LD = 2'd0;
  localparam logic [1:0] ST = 2'd1;
  localparam logic [1:0] FE = 2'd2;
  localparam logic [1:0] MISS  = 2'd0;
  localparam logic [1:0] GRANT = 2'd1;
  localparam logic [1:0] DENY  = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_instr = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic        wr_lower = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] lk_ea = '0;
  logic [1:0]  lk_kind = '0;
  logic        lk_user = 1'b0;
  logic [31:0] lk_pa;
  logic [2:0]  lk_perm;
  logic [1:0]  lk_status;
  logic [1:0]  lk_entry;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  blk_xlate_array u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_instr(wr_instr),
    .wr_idx(wr_idx), .wr_lower(wr_lower), .wr_data(wr_data),
    .lk_ea(lk_ea), .lk_kind(lk_kind), .lk_user(lk_user),
    .lk_pa(lk_pa), .lk_perm(lk_perm), .lk_status(lk_status), .lk_entry(lk_entry)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        user;
    logic [31:0] ea;
    logic [1:0]  st;
    logic [31:0] pa;
    logic [2:0]  perm;
    logic [1:0]  ent;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{LD, 1'b0, 32'h1000_0ABC, GRANT, 32'h8000_0ABC, 3'b111, 2'd0}, // R2 R5 R8
    '{ST, 1'b0, 32'h1001_F000, GRANT, 32'h8001_F000, 3'b111, 2'd0}, // R2 R8
    '{LD, 1'b0, 32'h1002_0000, MISS,  32'h0,         3'b000, 2'd0}, // R2 R9
    '{LD, 1'b1, 32'h1000_0010, MISS,  32'h0,         3'b000, 2'd0}, // R3
    '{LD, 1'b0, 32'h2ABC_DEF0, GRANT, 32'h4ABC_DEF0, 3'b101, 2'd1}, // R2 R4 R5
    '{ST, 1'b0, 32'h2000_1234, DENY,  32'h4000_1234, 3'b101, 2'd1}, // R6 R8
    '{ST, 1'b1, 32'h2123_4567, DENY,  32'h4123_4567, 3'b101, 2'd1}, // R3 R8
    '{LD, 1'b1, 32'h3045_6780, GRANT, 32'h5065_6780, 3'b111, 2'd2}, // R2 R5
    '{LD, 1'b0, 32'h3045_6780, MISS,  32'h0,         3'b000, 2'd0}, // R3
    '{LD, 1'b1, 32'h3050_0000, MISS,  32'h0,         3'b000, 2'd0}, // R2
    '{FE, 1'b0, 32'h1000_0ABC, GRANT, 32'hA000_0ABC, 3'b101, 2'd0}, // R7 R8
    '{FE, 1'b0, 32'h2000_0000, MISS,  32'h0,         3'b000, 2'd0}, // R7
    '{FE, 1'b1, 32'h6000_0004, DENY,  32'hB000_0004, 3'b000, 2'd1}, // R4 R8
    '{LD, 1'b0, 32'h6000_0004, MISS,  32'h0,         3'b000, 2'd0}, // R7
    '{LD, 1'b0, 32'h2000_0100, GRANT, 32'h4000_0100, 3'b101, 2'd1}, // R6
    '{ST, 1'b1, 32'h1000_0000, MISS,  32'h0,         3'b000, 2'd0}, // R3 R9
    '{2'd3, 1'b0, 32'h1000_0ABC, GRANT, 32'hA000_0ABC, 3'b101, 2'd0} // R7
  };

  task automatic wr_word(input logic side, input logic [1:0] idx,
                         input logic low, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_instr = side; wr_idx = idx; wr_lower = low; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [1:0] k, input logic u, input logic [31:0] a);
    @(negedge clk);
    lk_kind = k; lk_user = u; lk_ea = a;
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [1:0] st,
                            input logic [31:0] pa, input logic [2:0] pm,
                            input logic [1:0] en);
    checks++;
    if (lk_status !== st || lk_pa !== pa || lk_perm !== pm || lk_entry !== en) begin
      errors++;
      $display("FAIL %s: got st=%0d pa=%h perm=%b ent=%0d, expected st=%0d pa=%h perm=%b ent=%0d",
               tag, lk_status, lk_pa, lk_perm, lk_entry, st, pa, pm, en);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, both banks empty
    look(LD, 1'b0, 32'h1000_0ABC);
    expect_out("R1 data bank empty", MISS, 32'h0, 3'b000, 2'd0);
    look(FE, 1'b1, 32'h0000_0000);
    expect_out("R1 instr bank empty", MISS, 32'h0, 3'b000, 2'd0);

    // data bank
    wr_word(1'b0, 2'd0, 1'b0, 32'h1000_0002);
    wr_word(1'b0, 2'd0, 1'b1, 32'h8000_0002);
    wr_word(1'b0, 2'd1, 1'b0, 32'h2000_1FFF);
    wr_word(1'b0, 2'd1, 1'b1, 32'h4000_0001);
    wr_word(1'b0, 2'd2, 1'b0, 32'h3040_001D);
    wr_word(1'b0, 2'd2, 1'b1, 32'h5060_0002);
    wr_word(1'b0, 2'd3, 1'b0, 32'h2000_0003);
    wr_word(1'b0, 2'd3, 1'b1, 32'h9000_0002);
    // instruction bank
    wr_word(1'b1, 2'd0, 1'b0, 32'h1000_0002);
    wr_word(1'b1, 2'd0, 1'b1, 32'hA000_0001);
    wr_word(1'b1, 2'd1, 1'b0, 32'h6000_0003);
    wr_word(1'b1, 2'd1, 1'b1, 32'hB000_0000);

    for (int i = 0; i < NV; i++) begin
      look(VEC[i].kind, VEC[i].user, VEC[i].ea);
      expect_out($sformatf("table vec %0d (R2 R3 R4 R5 R6 R7 R8 R9)", i),
                 VEC[i].st, VEC[i].pa, VEC[i].perm, VEC[i].ent);
    end

    // R10: write visible only after the edge
    look(LD, 1'b0, 32'h1000_0ABC);
    @(negedge clk);
    wr_en = 1'b1; wr_instr = 1'b0; wr_idx = 2'd0; wr_lower = 1'b1; wr_data = 32'h8000_0000;
    #1;
    expect_out("R10 before edge", GRANT, 32'h8000_0ABC, 3'b111, 2'd0);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    expect_out("R10 after edge R4 code0", DENY, 32'h8000_0ABC, 3'b000, 2'd0);

    // R10 / R7: instruction-bank write leaves data bank alone
    wr_word(1'b1, 2'd0, 1'b0, 32'h0000_0000);
    look(LD, 1'b0, 32'h1000_0ABC);
    expect_out("R10 other bank untouched", DENY, 32'h8000_0ABC, 3'b000, 2'd0);
    look(FE, 1'b0, 32'h1000_0ABC);
    expect_out("R10 instr entry cleared", MISS, 32'h0, 3'b000, 2'd0);
    // R10: lower-word write leaves match of entry 1 in place
    wr_word(1'b0, 2'd1, 1'b1, 32'h7000_0003);
    look(LD, 1'b0, 32'h2000_0100);
    expect_out("R10 lower word only", GRANT, 32'h7000_0100, 3'b101, 2'd1);

    // R1: reset clears a loaded array
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    look(LD, 1'b0, 32'h2000_0100);
    expect_out("R1 after re-reset", MISS, 32'h0, 3'b000, 2'd0);
    look(LD, 1'b1, 32'h3045_6780);
    expect_out("R1 after re-reset user", MISS, 32'h0, 3'b000, 2'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule